// File: doc/BRIEF.md
# Dynamic Bus Width Splitter

The splitter takes one 32-bit request from a core (word address, four active-low byte enables, a read/write flag and write data) and carries it out on an external data bus whose width can change from one transfer to the next. Two active-low size inputs, one asking for a 16-bit width and one asking for an 8-bit width, are registered on every clock. The value captured at the edge before the ready edge sets the width of the transfer that ready completes.

When the chosen width cannot carry every byte still pending, the splitter accepts only the bytes that fit. It then starts a follow-up transfer at once, and that transfer's enables show just the bytes that remain. Write bytes are copied down onto the low lanes so that a narrow device finds them there. Read bytes are taken from the lanes a narrow device uses and stored in their natural positions. The core sees a single completion pulse after the last byte has been accepted.

Top module: `dbs_splitter`

## Requirements
- R1: While reset is held and after it ends with no request, bus_cyc and bus_start are 0, bus_be_n is 4'hF and core_done is 0.
- R2: When idle, a cycle with req_start high loads the request. In the next cycle bus_cyc and bus_start are 1, bus_be_n equals req_be_n, and bus_addr and bus_write match the request.
- R3: Both size inputs are registered at every clock edge. A transfer's width comes from the value registered at the edge before the edge that samples bus_rdy_n low. The input levels during the ready cycle itself have no effect on that transfer.
- R4: If both size inputs were registered low, the width is 8 bits.
- R5: At 32-bit width, a ready completes every pending byte.
- R6: At 16-bit width, a ready completes the pending bytes in the half holding the lowest pending byte (bytes 0-1 or 2-3). Byte k of that half travels on D7:0 if k is even and on D15:8 if k is odd.
- R7: At 8-bit width, a ready completes only the lowest pending byte, which travels on D7:0.
- R8: If bytes remain after a ready, the next cycle starts a new transfer. bus_start pulses for exactly that cycle, bus_be_n shows only the remaining bytes, and the width is decided again for that transfer.
- R9: For writes, each byte completed by a transfer is present on the lane given by R5, R6 or R7.
- R10: One cycle after the ready that completes the last byte, core_done is 1 for one cycle and bus_cyc is 0. core_rdata then holds the read bytes in their natural lanes (byte k at bits 8k+7:8k), with zero in the lanes of disabled bytes, and is zero after a write.
- R11: bus_rdy_n low while no transfer is active has no effect: no completion, and the bus stays idle.
- R12: A request with bus enables all high (req_be_n = 4'hF) runs no transfer and raises core_done in the next cycle with core_rdata zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Core request strobe, taken when idle |
| req_addr | input | ADDR_W | Core word address |
| req_be_n | input | 4 | Core byte enables, active low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Core write data, natural lanes |
| core_done | output | 1 | One-cycle completion pulse |
| core_rdata | output | 32 | Assembled read data |
| bus_cyc | output | 1 | A transfer is in progress |
| bus_start | output | 1 | First cycle of each transfer |
| bus_addr | output | ADDR_W | Word address on the bus |
| bus_be_n | output | 4 | Bus byte enables of pending bytes, active low |
| bus_write | output | 1 | Bus direction |
| bus_wdata | output | 32 | Steered write data |
| bus_rdata | input | 32 | Read data from the bus |
| bus_rdy_n | input | 1 | Transfer ready, active low |
| bus_bs16_n | input | 1 | 16-bit width request, active low |
| bus_bs8_n | input | 1 | 8-bit width request, active low |

## Verification
Two things can act on the same edge: the registering of new size-input levels, and the ready that closes a transfer. In some tests the bench changes the size inputs in the very ready cycle, to 8-bit where 32-bit was registered and the other way round. The bench expects the width from the earlier edge to decide how many bytes are accepted and on which lanes they travel. The scoreboard is judged on the enables of each follow-up transfer and on the word assembled at completion.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  localparam int NLANE  = 4;
  localparam int LANE_W = 8;
  localparam int IDX_W  = $clog2(NLANE);

  typedef enum logic [1:0] {
    BW32 = 2'd0,
    BW16 = 2'd1,
    BW8  = 2'd2
  } bw_e;

  // index of the lowest set bit; 0 when the mask is empty
  function automatic logic [IDX_W-1:0] low_idx(input logic [NLANE-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NLANE - 1; i >= 0; i--) begin
      if (m[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  // lanes a transfer of width w can carry, given the lowest pending byte
  function automatic logic [NLANE-1:0] lane_window(input bw_e w, input logic [IDX_W-1:0] lo);
    logic [NLANE-1:0] r;
    case (w)
      BW32:    r = '1;
      BW16:    r = lo[1] ? 4'b1100 : 4'b0011;
      default: r = 4'b0001 << lo;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dbs_size_sampler.sv
module dbs_size_sampler
  import dbs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bs16_n,
  input  logic bs8_n,
  output bw_e  width
);

  logic [1:0] pins_q;
  logic [1:0] pins_d;

  always_comb begin
    pins_d = {bs16_n, bs8_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= 2'b11;
    else        pins_q <= pins_d;
  end

  // 8-bit request has priority over 16-bit
  always_comb begin
    if (!pins_q[0])      width = BW8;
    else if (!pins_q[1]) width = BW16;
    else                 width = BW32;
  end

endmodule

// File: rtl/dbs_wr_steer.sv
module dbs_wr_steer
  import dbs_pkg::*;
(
  input  logic [NLANE*LANE_W-1:0] wd_in,
  input  logic [IDX_W-1:0]        lo,
  output logic [NLANE*LANE_W-1:0] wd_out
);

  always_comb begin
    wd_out = wd_in;
    // lowest pending byte always reaches D7:0
    wd_out[0 +: LANE_W]      = wd_in[lo*LANE_W +: LANE_W];
    // odd byte of the active half reaches D15:8
    wd_out[LANE_W +: LANE_W] = lo[1] ? wd_in[3*LANE_W +: LANE_W]
                                     : wd_in[LANE_W +: LANE_W];
  end

endmodule

// File: rtl/dbs_rd_gather.sv
module dbs_rd_gather
  import dbs_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    cap_en,
  input  logic [NLANE-1:0]        cap_mask,
  input  bw_e                     width,
  input  logic [NLANE*LANE_W-1:0] rd_bus,
  output logic [NLANE*LANE_W-1:0] hold
);

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int ODD = g % 2;
    logic [LANE_W-1:0] pick;
    logic [LANE_W-1:0] byte_d;
    logic [LANE_W-1:0] byte_q;

    always_comb begin
      case (width)
        BW32:    pick = rd_bus[g*LANE_W +: LANE_W];
        BW16:    pick = rd_bus[ODD*LANE_W +: LANE_W];
        default: pick = rd_bus[0 +: LANE_W];
      endcase
    end

    always_comb begin
      byte_d = byte_q;
      if (clr)                        byte_d = '0;
      else if (cap_en && cap_mask[g]) byte_d = pick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '0;
      else        byte_q <= byte_d;
    end

    assign hold[g*LANE_W +: LANE_W] = byte_q;
  end

endmodule

// File: rtl/dbs_splitter.sv
module dbs_splitter
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be_n,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  output logic              core_done,
  output logic [31:0]       core_rdata,
  output logic              bus_cyc,
  output logic              bus_start,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [3:0]        bus_be_n,
  output logic              bus_write,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_rdy_n,
  input  logic              bus_bs16_n,
  input  logic              bus_bs8_n
);

  localparam int DATA_W = NLANE * LANE_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // request state
  logic [NLANE-1:0]  rem_q, rem_d;
  logic              start_q, start_d;
  logic              done_q, done_d;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;

  bw_e              width_cur;
  logic             busy;
  logic             load;
  logic             xfer_done;
  logic [IDX_W-1:0] lo;
  logic [NLANE-1:0] acc;
  logic [NLANE-1:0] rem_after;
  logic [NLANE-1:0] req_en;

  dbs_size_sampler u_size (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .bs16_n (bus_bs16_n),
    .bs8_n  (bus_bs8_n),
    .width  (width_cur)
  );

  always_comb begin
    req_en    = ~req_be_n;
    busy      = |rem_q;
    load      = req_start && !busy;
    xfer_done = busy && !bus_rdy_n;
    lo        = low_idx(rem_q);
    acc       = rem_q & lane_window(width_cur, lo);
    rem_after = rem_q & ~acc;
  end

  // next state
  always_comb begin
    rem_d   = rem_q;
    start_d = 1'b0;
    done_d  = 1'b0;
    if (load) begin
      rem_d   = req_en;
      start_d = |req_en;
      done_d  = ~|req_en;
    end else if (xfer_done) begin
      rem_d   = rem_after;
      start_d = |rem_after;
      done_d  = ~|rem_after;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rem_q   <= '0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      rem_q   <= rem_d;
      start_q <= start_d;
      done_q  <= done_d;
    end
  end

  // request fields, clock enable on load
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (load) begin
      addr_q  <= req_addr;
      wr_q    <= req_write;
      wdata_q <= req_wdata;
    end
  end

  dbs_wr_steer u_steer (
    .wd_in  (wdata_q),
    .lo     (lo),
    .wd_out (bus_wdata)
  );

  dbs_rd_gather u_gather (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr      (load),
    .cap_en   (xfer_done && !wr_q),
    .cap_mask (acc),
    .width    (width_cur),
    .rd_bus   (bus_rdata),
    .hold     (core_rdata)
  );

  assign bus_cyc   = busy;
  assign bus_start = start_q;
  assign bus_be_n  = ~rem_q;
  assign bus_addr  = addr_q;
  assign bus_write = wr_q;
  assign core_done = done_q;

endmodule

// File: rtl/dbs_splitter_chk.sv
module dbs_splitter_chk
  import dbs_pkg::*;
(
  input logic       clk,
  input logic       rst_int_n,
  input logic       req_start,
  input logic       core_done,
  input logic       bus_cyc,
  input logic       bus_start,
  input logic [3:0] bus_be_n,
  input logic       bus_rdy_n,
  input bw_e        width_sel
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_cyc |-> (bus_be_n == 4'hF) && !bus_start);

  a_r2_start_in_cycle: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_start |-> bus_cyc);

  a_r5_word_completes: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_cyc && !bus_rdy_n && width_sel == BW32) |=> (core_done && !bus_cyc));

  a_r7_single_byte: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_cyc && !bus_rdy_n && width_sel == BW8) |=>
      ($countones(~bus_be_n) == $countones(~$past(bus_be_n)) - 1));

  a_r8_no_new_bytes: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_cyc && !bus_rdy_n) |=> (((~bus_be_n) & $past(bus_be_n)) == 4'h0));

  a_r10_done_when_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    core_done |-> !bus_cyc);

  a_r11_idle_ready: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!bus_cyc && !bus_rdy_n && !req_start) |=> !core_done);

endmodule

bind dbs_splitter dbs_splitter_chk u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .req_start (req_start),
  .core_done (core_done),
  .bus_cyc   (bus_cyc),
  .bus_start (bus_start),
  .bus_be_n  (bus_be_n),
  .bus_rdy_n (bus_rdy_n),
  .width_sel (width_cur)
);

// File: tb/dbs_splitter_test.sv
module dbs_splitter_test;

  localparam int AW = 30;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_start;
  logic [AW-1:0] req_addr;
  logic [3:0]    req_be_n;
  logic          req_write;
  logic [31:0]   req_wdata;
  logic          core_done;
  logic [31:0]   core_rdata;
  logic          bus_cyc, bus_start, bus_write;
  logic [AW-1:0] bus_addr;
  logic [3:0]    bus_be_n;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          bus_rdy_n, bus_bs16_n, bus_bs8_n;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  bit running = 1'b0;

  always #5 clk = ~clk;

  dbs_splitter #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_start(req_start), .req_addr(req_addr), .req_be_n(req_be_n),
    .req_write(req_write), .req_wdata(req_wdata),
    .core_done(core_done), .core_rdata(core_rdata),
    .bus_cyc(bus_cyc), .bus_start(bus_start), .bus_addr(bus_addr),
    .bus_be_n(bus_be_n), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdy_n(bus_rdy_n),
    .bus_bs16_n(bus_bs16_n), .bus_bs8_n(bus_bs8_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  // width codes: 0 = 32-bit, 1 = 16-bit, 2 = 8-bit, 3 = both pins low
  task automatic set_pins(input logic [1:0] code);
    bus_bs16_n = !(code == 2'd1 || code == 2'd3);
    bus_bs8_n  = !(code == 2'd2 || code == 2'd3);
  endtask

  // monitor: compares every completion against the scoreboard
  always @(negedge clk) begin
    if (running && core_done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected completion", 32'd1, 32'd0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(core_rdata == e, "R10 assembled data", core_rdata, e);
      end
    end
  end

  // driver: one core request, widths per transfer (codes), pin levels in ready cycle (late)
  task automatic run_req(input logic [AW-1:0] a, input logic [3:0] be, input bit wr,
                         input logic [31:0] wd, input logic [31:0] rword,
                         input logic [7:0] codes, input logic [7:0] late, input string tag);
    logic [3:0]  rem;
    logic [3:0]  acc;
    logic [31:0] exp_w;
    int          k;
    @(negedge clk);
    req_addr = a; req_be_n = be; req_write = wr; req_wdata = wd; req_start = 1'b1;
    if (be == 4'hF) exp_q.push_back(32'd0);
    @(negedge clk);
    req_start = 1'b0;
    rem = ~be;
    exp_w = 32'd0;
    k = 0;
    if (be == 4'hF) begin
      chk(bus_cyc == 1'b0, "R12 no transfer", {31'd0, bus_cyc}, 32'd0);
      chk(core_done == 1'b1, "R12 immediate done", {31'd0, core_done}, 32'd1);
    end else begin
      chk(bus_addr == a, "R2 address", 32'(bus_addr), 32'(a));
      chk(bus_write == wr, "R2 direction", {31'd0, bus_write}, {31'd0, wr});
    end
    while (rem != 4'h0) begin
      logic [1:0] code;
      int lo;
      int w;
      code = codes[2*k +: 2];
      chk(bus_cyc && bus_start, {tag, " R8 start pulse"}, {30'd0, bus_cyc, bus_start}, 32'd3);
      chk(bus_be_n == ~rem, {tag, " R8 enables"}, {28'd0, bus_be_n}, {28'd0, ~rem});
      set_pins(code);
      @(negedge clk);
      chk(bus_start == 1'b0, {tag, " R8 start one cycle"}, {31'd0, bus_start}, 32'd0);
      set_pins(late[2*k +: 2]);
      w = (code == 2'd0) ? 32 : (code == 2'd1) ? 16 : 8;
      lo = 0;
      for (int i = 3; i >= 0; i--) if (rem[i]) lo = i;
      if (w == 32)      acc = rem;
      else if (w == 16) acc = rem & ((lo >= 2) ? 4'b1100 : 4'b0011);
      else              acc = 4'b0001 << lo;
      bus_rdata = 32'hA5C3_5A3C;
      if (w == 32)      bus_rdata = rword;
      else if (w == 16) bus_rdata[15:0] = (lo >= 2) ? rword[31:16] : rword[15:0];
      else              bus_rdata[7:0] = rword[8*lo +: 8];
      for (int i = 0; i < 4; i++) begin
        if (acc[i]) begin
          int p;
          p = (w == 32) ? i : (w == 16) ? (i % 2) : 0;
          if (wr) chk(bus_wdata[8*p +: 8] == wd[8*i +: 8], {tag, " R9 write lane"},
                      32'(bus_wdata[8*p +: 8]), 32'(wd[8*i +: 8]));
          else    exp_w[8*i +: 8] = rword[8*i +: 8];
        end
      end
      rem = rem & ~acc;
      if (rem == 4'h0) exp_q.push_back(exp_w);
      bus_rdy_n = 1'b0;
      @(negedge clk);
      bus_rdy_n = 1'b1;
      set_pins(2'd0);
      k++;
    end
    if (be != 4'hF) begin
      chk(bus_cyc == 1'b0, {tag, " R10 bus idle at done"}, {31'd0, bus_cyc}, 32'd0);
      chk(core_done == 1'b1, {tag, " R10 done pulse"}, {31'd0, core_done}, 32'd1);
      @(negedge clk);
      chk(core_done == 1'b0, {tag, " R10 done one cycle"}, {31'd0, core_done}, 32'd0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_start = 1'b0; req_addr = '0; req_be_n = 4'hF; req_write = 1'b0; req_wdata = '0;
    bus_rdata = '0; bus_rdy_n = 1'b1; bus_bs16_n = 1'b1; bus_bs8_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!bus_cyc && !bus_start && bus_be_n == 4'hF && !core_done, "R1 reset state",
        {26'd0, bus_cyc, bus_start, bus_be_n}, {26'd0, 2'b00, 4'hF});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    running = 1'b1;
    chk(!bus_cyc && bus_be_n == 4'hF && !core_done, "R1 idle after reset",
        {27'd0, bus_cyc, bus_be_n}, {27'd0, 1'b0, 4'hF});

    run_req(30'h0001234, 4'b0000, 1'b0, 32'h0, 32'h4433_2211, 8'h00, 8'h00, "R5 32-bit read");
    run_req(30'h0000100, 4'b0000, 1'b0, 32'h0, 32'h8877_6655, 8'h55, 8'h55, "R6 16-bit read");
    run_req(30'h0000200, 4'b0000, 1'b0, 32'h0, 32'hDDCC_BBAA, 8'hAA, 8'hAA, "R7 8-bit read");
    run_req(30'h0000300, 4'b0000, 1'b0, 32'h0, 32'h1357_9BDF, 8'hFF, 8'hFF, "R4 both pins");
    run_req(30'h0000400, 4'b0110, 1'b0, 32'h0, 32'hF00D_BEEF, 8'h05, 8'h05, "R6 split halves");
    run_req(30'h0000500, 4'b0000, 1'b1, 32'hCAFE_F00D, 32'h0, 8'h06, 8'h06, "R8 mixed widths write");
    run_req(30'h0000600, 4'b0111, 1'b1, 32'h7E00_0000, 32'h0, 8'h02, 8'h02, "R9 top byte 8-bit write");
    run_req(30'h0000700, 4'b1100, 1'b1, 32'h0000_ABCD, 32'h0, 8'h01, 8'h01, "R9 low half 16-bit write");
    run_req(30'h0000800, 4'b0000, 1'b0, 32'h0, 32'h2468_ACE0, 8'h00, 8'h02, "R3 late 8-bit ignored");
    run_req(30'h0000900, 4'b0001, 1'b0, 32'h0, 32'h0BAD_CAFE, 8'h12, 8'h10, "R3 late 32-bit ignored");

    // R11: ready while idle
    @(negedge clk);
    bus_rdy_n = 1'b0;
    @(negedge clk);
    bus_rdy_n = 1'b1;
    chk(!bus_cyc && bus_be_n == 4'hF && !core_done, "R11 idle ready ignored",
        {27'd0, core_done, bus_be_n}, {27'd0, 1'b0, 4'hF});

    run_req(30'h0000A00, 4'b1111, 1'b0, 32'h0, 32'h0, 8'h00, 8'h00, "R12 empty enables");
    @(negedge clk);
    chk(exp_q.size() == 0, "R10 all completions seen", 32'(exp_q.size()), 32'd0);

    summary();
    $finish;
  end

endmodule